// File: doc/BRIEF.md
# Eight-Word Burst Program Loader

This block sits between a flash host interface and the program engine of a memory array. When the high-voltage enable is asserted, a host write strobe carrying the burst command code opens an eight-word program burst. The first address-valid pulse that follows sets the start word address. The block clears the low three bits of that address, so the burst always covers one aligned group of eight words. The next eight write-strobe rising edges each load one data word, and the word address advances by one per strobe.

After the eighth word, the block goes busy and issues eight array write requests, one per core clock, to consecutive addresses. It then pulses done and returns to read mode. If the enable drops before all eight words are loaded, the partial burst is discarded and an error flag is raised.

The host bus clock plays no part in this operation. Only the edges of the address-valid and write strobes pace the load. The block samples those strobes with its own core clock.

Top module: `burst8_loader`

## Requirements
- R1: A write-strobe rising edge with data low byte 0xA0 opens a burst only while `hv_en` is 1. With `hv_en` at 0, or with any other data code, the strobe is ignored, and later address and data strobes cause no array write.
- R2: Once the burst is open, the first address-valid rising edge sets the base address to `bus_addr` with bits [2:0] forced to 0.
- R3: Each of the next eight write-strobe rising edges loads one data word. Word i (0..7) is written to base + i with the data given on strobe i.
- R4: After the eighth word, `busy` is high for exactly eight core cycles. `arr_wr_en` is high in each of those cycles, and the array address rises by one per cycle.
- R5: `done` is a single-cycle pulse in the cycle after the last array write. The block then accepts a new burst command.
- R6: If `hv_en` falls while a burst is open but before the eighth word, the burst is discarded, no array write occurs, and `err` is set.
- R7: `err` stays set until the next accepted burst command clears it.
- R8: Strobes that arrive while `busy` is high are ignored. They neither change the burst under way nor open a new one.
- R9: After reset, `busy`, `done`, `err` and `arr_wr_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples the strobes |
| rst_n | input | 1 | Active-low asynchronous reset |
| hv_en | input | 1 | Supervoltage present on the acceleration pin |
| adv | input | 1 | Address-valid strobe, latches on its rising edge |
| wr_stb | input | 1 | Write strobe, latches on its rising edge |
| bus_addr | input | AW | Host word address |
| bus_data | input | DW | Host data word or command code |
| arr_wr_en | output | 1 | Array write request |
| arr_wr_addr | output | AW | Array word address |
| arr_wr_data | output | DW | Array write data |
| busy | output | 1 | Program phase in progress |
| done | output | 1 | One-cycle burst completion pulse |
| err | output | 1 | Burst aborted by loss of enable |

## Verification
The assertions take for granted that every strobe stays high for at least one core cycle and then low for at least one core cycle. They also assume that `bus_addr` and `bus_data` are stable at the sampled rising edge, so that each host pulse appears as exactly one detected edge. The bench drives every strobe from a task that changes inputs on the falling clock edge and holds each level for a full cycle. `hv_en` is only changed between strobe pulses, so each abort is seen in a defined state.

// File: rtl/burst8_loader.sv
module burst8_loader #(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int WORDS = 8,
  parameter logic [7:0] CMD = 8'hA0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hv_en,
  input  logic          adv,
  input  logic          wr_stb,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  output logic          arr_wr_en,
  output logic [AW-1:0] arr_wr_addr,
  output logic [DW-1:0] arr_wr_data,
  output logic          busy,
  output logic          done,
  output logic          err
);
  localparam int IW = $clog2(WORDS);
  localparam logic [IW-1:0] LAST = IW'(WORDS - 1);

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_LOAD, S_PROG, S_DONE} st_t;

  st_t           st;
  logic          adv_q, we_q;
  logic [IW-1:0] idx;
  logic [AW-1:0] base;
  logic [DW-1:0] words_q [WORDS];

  wire adv_rise = adv & ~adv_q;
  wire we_rise  = wr_stb & ~we_q;
  wire cmd_hit  = we_rise && (bus_data[7:0] == CMD) && hv_en;

  assign busy        = (st == S_PROG);
  assign done        = (st == S_DONE);
  assign arr_wr_en   = busy;
  assign arr_wr_addr = base + AW'(idx);
  assign arr_wr_data = words_q[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adv_q <= 1'b0;
      we_q  <= 1'b0;
    end else begin
      adv_q <= adv;
      we_q  <= wr_stb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      idx  <= '0;
      base <= '0;
      err  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (cmd_hit) begin
          st  <= S_ARM;
          err <= 1'b0;
        end
        S_ARM: begin
          if (!hv_en) begin
            st  <= S_IDLE;
            err <= 1'b1;
          end else if (adv_rise) begin
            base <= {bus_addr[AW-1:IW], {IW{1'b0}}};
            idx  <= '0;
            st   <= S_LOAD;
          end
        end
        S_LOAD: begin
          if (!hv_en) begin
            st  <= S_IDLE;
            err <= 1'b1;
          end else if (we_rise) begin
            idx <= idx + 1'b1;
            if (idx == LAST) st <= S_PROG;
          end
        end
        S_PROG: begin
          idx <= idx + 1'b1;
          if (idx == LAST) st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_LOAD && hv_en && we_rise) words_q[idx] <= bus_data;
  end

  p_base_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> arr_wr_addr[IW-1:0] == '0);

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr_en && $past(arr_wr_en)) |-> arr_wr_addr == $past(arr_wr_addr) + 1'b1);

  p_done_follows_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_LOAD || st == S_ARM) && !hv_en) |=> (err && !busy));

  p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !cmd_hit) |=> err);

  p_busy_base_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(base));

endmodule

// File: tb/burst8_loader_tb.sv
module burst8_loader_tb;
  localparam int AW = 20;
  localparam int DW = 16;

  logic clk = 0, rst_n = 0, hv_en = 0, adv = 0, wr_stb = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_data = '0;
  logic arr_wr_en, busy, done, err;
  logic [AW-1:0] arr_wr_addr;
  logic [DW-1:0] arr_wr_data;

  int n_chk = 0, n_fail = 0;
  int n_wr = 0, n_busy = 0, n_done = 0;
  logic [AW-1:0] rec_a [16];
  logic [DW-1:0] rec_d [16];

  always #4 clk = ~clk;

  burst8_loader u_dut (
    .clk(clk), .rst_n(rst_n), .hv_en(hv_en), .adv(adv), .wr_stb(wr_stb),
    .bus_addr(bus_addr), .bus_data(bus_data), .arr_wr_en(arr_wr_en),
    .arr_wr_addr(arr_wr_addr), .arr_wr_data(arr_wr_data),
    .busy(busy), .done(done), .err(err)
  );

  always @(posedge clk) begin
    #2;
    if (arr_wr_en) begin
      if (n_wr < 16) begin
        rec_a[n_wr] = arr_wr_addr;
        rec_d[n_wr] = arr_wr_data;
      end
      n_wr++;
    end
    if (busy) n_busy++;
    if (done) n_done++;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    @(negedge clk);
    n_wr = 0; n_busy = 0; n_done = 0;
  endtask

  task automatic pulse_wr(input logic [DW-1:0] d);
    @(negedge clk); bus_data = d; wr_stb = 1;
    @(negedge clk); wr_stb = 0;
  endtask

  task automatic pulse_adv(input logic [AW-1:0] a);
    @(negedge clk); bus_addr = a; adv = 1;
    @(negedge clk); adv = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic burst(input logic [AW-1:0] a, input logic [DW-1:0] seed);
    pulse_wr(16'h00A0);
    pulse_adv(a);
    for (int i = 0; i < 8; i++) pulse_wr(seed + DW'(i * 3));
  endtask

  task automatic t_reset();
    chk(!busy && !done && !err && !arr_wr_en, "R9 reset outputs", {busy, done, err, arr_wr_en}, 0);
  endtask

  task automatic t_normal(input logic [AW-1:0] a, input logic [DW-1:0] seed, input string tag);
    logic [AW-1:0] b;
    b = {a[AW-1:3], 3'b000};
    clr();
    hv_en = 1;
    burst(a, seed);
    idle(14);
    chk(n_wr == 8, {tag, " R4 write count"}, n_wr, 8);
    chk(n_busy == 8, {tag, " R4 busy cycles"}, n_busy, 8);
    chk(n_done == 1, {tag, " R5 done pulses"}, n_done, 1);
    chk(rec_a[0] == b, {tag, " R2 aligned base"}, rec_a[0], b);
    for (int i = 0; i < 8; i++) begin
      chk(rec_a[i] == b + AW'(i), {tag, " R3 word address"}, rec_a[i], b + AW'(i));
      chk(rec_d[i] == seed + DW'(i * 3), {tag, " R3 word data"}, rec_d[i], seed + DW'(i * 3));
    end
    chk(!err && !busy, {tag, " R5 back to idle"}, {err, busy}, 0);
  endtask

  task automatic t_no_hv();
    clr();
    hv_en = 0;
    burst(20'h00040, 16'h5000);
    idle(14);
    chk(n_wr == 0, "R1 no burst without hv_en", n_wr, 0);
    chk(!err, "R1 no error without hv_en", err, 0);
  endtask

  task automatic t_bad_code();
    clr();
    hv_en = 1;
    pulse_wr(16'h0090);
    pulse_adv(20'h00080);
    for (int i = 0; i < 8; i++) pulse_wr(16'h1111);
    idle(14);
    chk(n_wr == 0, "R1 non-command code ignored", n_wr, 0);
  endtask

  task automatic t_abort();
    clr();
    hv_en = 1;
    pulse_wr(16'h00A0);
    pulse_adv(20'h00100);
    for (int i = 0; i < 3; i++) pulse_wr(16'h2222);
    hv_en = 0;
    idle(3);
    chk(err, "R6 err after enable drop", err, 1);
    hv_en = 1;
    for (int i = 0; i < 5; i++) pulse_wr(16'h3333);
    idle(14);
    chk(n_wr == 0, "R6 partial burst discarded", n_wr, 0);
    chk(err, "R7 err held while idle", err, 1);
    pulse_wr(16'h00A0);
    idle(2);
    chk(!err, "R7 err cleared by new command", err, 0);
    pulse_adv(20'h00200);
    for (int i = 0; i < 8; i++) pulse_wr(16'h4000 + DW'(i));
    idle(14);
    chk(n_wr == 8 && rec_a[7] == 20'h00207, "R7 burst after recovery", rec_a[7], 20'h00207);
  endtask

  task automatic t_busy_ignore();
    clr();
    hv_en = 1;
    burst(20'h00300, 16'h6000);
    pulse_adv(20'h00777);
    pulse_wr(16'h00A0);
    idle(10);
    chk(n_wr == 8, "R8 strobes during busy, write count", n_wr, 8);
    chk(rec_a[7] == 20'h00307, "R8 address unchanged", rec_a[7], 20'h00307);
    clr();
    pulse_adv(20'h00400);
    for (int i = 0; i < 8; i++) pulse_wr(16'h1111);
    idle(14);
    chk(n_wr == 0, "R8 no burst opened during busy", n_wr, 0);
  endtask

  initial begin
    fork
      begin
        idle(3);
        @(negedge clk); rst_n = 1;
        idle(2);
        t_reset();
        t_normal(20'h01230, 16'hA5A0, "aligned R1");
        t_normal(20'h0456D, 16'h0F00, "unaligned");
        t_normal(20'hFFFFF, 16'h7770, "top");
        t_no_hv();
        t_bad_code();
        t_abort();
        t_busy_ignore();
      end
      begin
        #(8 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule